// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Overlap Purge

This block is a small fully associative translation lookaside buffer that software fills one slot at a time. It does not walk page tables in memory and has no replacement policy: the loader chooses the slot index. Each slot holds a virtual page number, a physical page number, a page size, four 1 KB subpage valid flags (used only by 4 KB pages), a supervisor-only flag, an address space identifier, a shared flag that makes the slot match in every address space, and a small attribute field whose bits (for example cacheable) the block returns unchanged.

Lookup is combinational from the stored slots. It takes a virtual address, the requester's privilege and the current address space identifier, and returns hit, the physical address and the attributes. A user-mode access that lands on a supervisor-only slot is reported as a protection fault and not as a hit. A write stores the new slot in one cycle. In that same cycle it clears every other resident slot that could be hit by the same lookups as the new one, so a lookup never matches more than one slot. A flush input empties the buffer in one cycle.

Top module: `soft_tlb`

## Requirements
- R1: After reset no slot is valid, and every lookup returns hit_o=0, fault_o=0, pa_o=0, attr_o=0.
- R2: A lookup hits a valid slot when the address bits above the page offset equal the slot's virtual page. pa_o then carries the slot's physical page bits above the offset and the lookup address bits within the offset, and attr_o carries the slot's attributes. On a miss pa_o and attr_o are zero.
- R3: wr_size_i selects the page size: 0 is 4 KB, 1 is 16 KB, and 2 or 3 is 512 KB. The low 12, 14 or 19 address bits are left out of the compare and pass straight through to pa_o. Page number bits below the page size are ignored in both pages.
- R4: In a 4 KB slot, bit k of the subpage flags covers lookup addresses with bits [11:10] equal to k, and a lookup hits only if that flag is set. Larger pages ignore the flags.
- R5: A slot with the shared flag clear matches only when lk_asid_i equals its stored identifier. A slot with the shared flag set matches any identifier.
- R6: A lookup with lk_sup_i=0 that matches a supervisor-only slot gives fault_o=1, hit_o=0, pa_o=0 and attr_o=0. The same lookup with lk_sup_i=1 hits.
- R7: A write with wr_en_i=1 takes effect at the next clock edge. It replaces whatever the target slot held, and a lookup in the following cycle sees the new contents. A lookup in the write cycle still sees the old contents.
- R8: A write clears every other valid slot whose address range intersects the new page. This applies when both identifiers are equal or either slot is shared. The one exception is when both pages are 4 KB and they share no set subpage flag. The supervisor-only flag does not protect a slot from being cleared.
- R9: No lookup ever matches more than one slot.
- R10: flush_i=1 clears every slot at the next edge, and a write in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear all slots |
| wr_en_i | input | 1 | Write the slot given by wr_idx_i |
| wr_idx_i | input | 3 | Target slot |
| wr_vpn_i | input | 20 | Virtual page number (address bits 31:12) |
| wr_ppn_i | input | 20 | Physical page number (address bits 31:12) |
| wr_size_i | input | 2 | Page size code |
| wr_sub_v_i | input | 4 | Subpage valid flags for 4 KB pages |
| wr_sup_i | input | 1 | Supervisor-only page |
| wr_asid_i | input | 4 | Address space identifier |
| wr_shared_i | input | 1 | Match in every address space |
| wr_attr_i | input | 4 | Page attributes |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_sup_i | input | 1 | Lookup is at supervisor privilege |
| lk_asid_i | input | 4 | Current address space identifier |
| hit_o | output | 1 | Lookup translated |
| fault_o | output | 1 | User lookup hit a supervisor-only page |
| pa_o | output | 32 | Physical address |
| attr_o | output | 4 | Attributes of the hit page |

## Verification
The bench uses the default build: eight slots, a 4-bit identifier and 32-bit addresses. Its random phase draws page numbers and lookup addresses from a 2 MB window and identifiers from only four values. Under these limits, pages of all three sizes regularly collide with one another on writes. This covers mixed-size overlaps, shared-against-private purges and subpage-disjoint 4 KB pairs, and a reference that works on byte ranges checks the outcome every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int ADDR_W = 32;
  parameter int ASID_W = 4;
  parameter int ATTR_W = 4;
  parameter int SUB_N  = 4;
  localparam int OFF_W   = 12;
  localparam int PN_W    = ADDR_W - OFF_W;
  localparam int SUB_W   = $clog2(SUB_N);
  localparam int SH_16K  = 2;
  localparam int SH_512K = 7;

  typedef enum logic [1:0] {
    PG_4K    = 2'd0,
    PG_16K   = 2'd1,
    PG_512K  = 2'd2,
    PG_512K2 = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              valid;
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   ppn;
    pg_size_e          size;
    logic [SUB_N-1:0]  sub_v;
    logic              sup;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic [ATTR_W-1:0] attr;
  } tlb_ent_t;

  // ones on page-number bits that take part in the compare
  function automatic logic [PN_W-1:0] pg_mask(pg_size_e s);
    logic [PN_W-1:0] m;
    m = '1;
    case (s)
      PG_4K:   m = '1;
      PG_16K:  m = m << SH_16K;
      default: m = m << SH_512K;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_sel_i,
  input  logic              wr_any_i,
  input  tlb_ent_t          wr_ent_i,
  input  logic [PN_W-1:0]   lk_vpn_i,
  input  logic [SUB_W-1:0]  lk_sub_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              match_o,
  output tlb_ent_t          ent_o
);
  tlb_ent_t ent_q;
  logic     kill;

  always_comb begin
    logic [PN_W-1:0] m;
    logic            addr_eq, asid_ok, sub_ok, both_4k;
    m       = pg_mask(ent_q.size) & pg_mask(wr_ent_i.size);
    addr_eq = ((ent_q.vpn ^ wr_ent_i.vpn) & m) == '0;
    asid_ok = ent_q.shared || wr_ent_i.shared || (ent_q.asid == wr_ent_i.asid);
    both_4k = (ent_q.size == PG_4K) && (wr_ent_i.size == PG_4K);
    sub_ok  = !both_4k || |(ent_q.sub_v & wr_ent_i.sub_v);
    kill    = wr_any_i && !wr_sel_i && ent_q.valid && addr_eq && asid_ok && sub_ok;
  end

  always_comb begin
    logic addr_eq, asid_ok, sub_ok;
    addr_eq = ((ent_q.vpn ^ lk_vpn_i) & pg_mask(ent_q.size)) == '0;
    asid_ok = ent_q.shared || (ent_q.asid == lk_asid_i);
    sub_ok  = (ent_q.size != PG_4K) || ent_q.sub_v[lk_sub_i];
    match_o = ent_q.valid && addr_eq && asid_ok && sub_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ent_q <= '0;
    else if (flush_i)  ent_q.valid <= 1'b0;
    else if (wr_sel_i) ent_q <= wr_ent_i;
    else if (kill)     ent_q.valid <= 1'b0;
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/tlb_sel.sv
module tlb_sel
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic [N_ENT-1:0] match_i,
  input  tlb_ent_t         ents_i [N_ENT],
  output tlb_ent_t         sel_o
);
  // AND-OR mux; at most one match by construction of the write path
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N_ENT; i++)
      sel_o = sel_o | (ents_i[i] & {$bits(tlb_ent_t){match_i[i]}});
  end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PN_W-1:0]   wr_vpn_i,
  input  logic [PN_W-1:0]   wr_ppn_i,
  input  logic [1:0]        wr_size_i,
  input  logic [SUB_N-1:0]  wr_sub_v_i,
  input  logic              wr_sup_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_shared_i,
  input  logic [ATTR_W-1:0] wr_attr_i,
  input  logic [ADDR_W-1:0] lk_va_i,
  input  logic              lk_sup_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [ATTR_W-1:0] attr_o
);
  tlb_ent_t         wr_ent;
  tlb_ent_t         ents [N_ENT];
  tlb_ent_t         sel;
  logic [N_ENT-1:0] match_v;
  logic             wr_any;

  assign wr_any = wr_en_i && !flush_i;

  always_comb begin
    wr_ent        = '0;
    wr_ent.valid  = 1'b1;
    wr_ent.vpn    = wr_vpn_i;
    wr_ent.ppn    = wr_ppn_i;
    wr_ent.size   = pg_size_e'(wr_size_i);
    wr_ent.sub_v  = wr_sub_v_i;
    wr_ent.sup    = wr_sup_i;
    wr_ent.asid   = wr_asid_i;
    wr_ent.shared = wr_shared_i;
    wr_ent.attr   = wr_attr_i;
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    tlb_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .wr_sel_i  (wr_any && (wr_idx_i == IDX_W'(i))),
      .wr_any_i  (wr_any),
      .wr_ent_i  (wr_ent),
      .lk_vpn_i  (lk_va_i[ADDR_W-1:OFF_W]),
      .lk_sub_i  (lk_va_i[OFF_W-1 -: SUB_W]),
      .lk_asid_i (lk_asid_i),
      .match_o   (match_v[i]),
      .ent_o     (ents[i])
    );
  end

  tlb_sel #(.N_ENT(N_ENT)) u_sel (
    .match_i (match_v),
    .ents_i  (ents),
    .sel_o   (sel)
  );

  always_comb begin
    logic            any, deny;
    logic [PN_W-1:0] m, pn;
    any     = |match_v;
    deny    = sel.sup && !lk_sup_i;
    hit_o   = any && !deny;
    fault_o = any && deny;
    m       = pg_mask(sel.size);
    pn      = (sel.ppn & m) | (lk_va_i[ADDR_W-1:OFF_W] & ~m);
    pa_o    = hit_o ? {pn, lk_va_i[OFF_W-1:0]} : '0;
    attr_o  = hit_o ? sel.attr : '0;
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              lk_sup_i,
  input logic [ADDR_W-1:0] lk_va_i,
  input logic              hit_o,
  input logic              fault_o,
  input logic [ADDR_W-1:0] pa_o,
  input logic [ATTR_W-1:0] attr_o,
  input logic [N_ENT-1:0]  match_v
);
  assert_single_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_v));

  assert_hit_fault_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o));

  assert_fault_user_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !lk_sup_i);

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> (!hit_o && !fault_o));

  assert_offset_passthru_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pa_o[OFF_W-1:0] == lk_va_i[OFF_W-1:0]));

  assert_miss_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0 && attr_o == '0));
endmodule

bind soft_tlb tlb_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .flush_i  (flush_i),
  .lk_sup_i (lk_sup_i),
  .lk_va_i  (lk_va_i),
  .hit_o    (hit_o),
  .fault_o  (fault_o),
  .pa_o     (pa_o),
  .attr_o   (attr_o),
  .match_v  (match_v)
);

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 0, wr_en_i = 0, wr_sup_i = 0, wr_shared_i = 0, lk_sup_i = 0;
  logic [2:0]  wr_idx_i = '0;
  logic [19:0] wr_vpn_i = '0, wr_ppn_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [3:0]  wr_sub_v_i = '0, wr_asid_i = '0, wr_attr_i = '0, lk_asid_i = '0;
  logic [31:0] lk_va_i = '0;
  logic        hit_o, fault_o;
  logic [31:0] pa_o;
  logic [3:0]  attr_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  soft_tlb dut (.*);

  // behavioural reference: byte ranges
  bit       m_v[8];
  bit [19:0] m_vpn[8], m_ppn[8];
  bit [1:0] m_sz[8];
  bit [3:0] m_sub[8], m_asid[8], m_attr[8];
  bit       m_sup[8], m_sh[8];

  function automatic longint pbytes(bit [1:0] s);
    return (s == 0) ? 64'd4096 : (s == 1) ? 64'd16384 : 64'd524288;
  endfunction

  function automatic longint pbase(bit [19:0] pn, bit [1:0] s);
    longint a = longint'(pn) * 4096;
    return a - (a % pbytes(s));
  endfunction

  task automatic model_lookup(output bit h, output bit f, output bit [31:0] pa, output bit [3:0] at);
    h = 0; f = 0; pa = 0; at = 0;
    for (int i = 0; i < 8; i++) begin
      longint b = pbase(m_vpn[i], m_sz[i]);
      longint va = longint'(lk_va_i);
      if (m_v[i] && va >= b && va < b + pbytes(m_sz[i]) &&
          (m_sh[i] || m_asid[i] == lk_asid_i) &&
          (m_sz[i] != 0 || m_sub[i][lk_va_i[11:10]])) begin
        if (m_sup[i] && !lk_sup_i) f = 1;
        else begin
          h  = 1;
          pa = 32'(pbase(m_ppn[i], m_sz[i]) + va % pbytes(m_sz[i]));
          at = m_attr[i];
        end
      end
    end
  endtask

  task automatic model_update();
    if (flush_i) begin
      for (int i = 0; i < 8; i++) m_v[i] = 0;
    end else if (wr_en_i) begin
      longint bn = pbase(wr_vpn_i, wr_size_i);
      longint en = bn + pbytes(wr_size_i);
      for (int i = 0; i < 8; i++) begin
        longint bi = pbase(m_vpn[i], m_sz[i]);
        longint ei = bi + pbytes(m_sz[i]);
        if (i != int'(wr_idx_i) && m_v[i] && bi < en && bn < ei &&
            (m_sh[i] || wr_shared_i || m_asid[i] == wr_asid_i) &&
            !(m_sz[i] == 0 && wr_size_i == 0 && (m_sub[i] & wr_sub_v_i) == 0))
          m_v[i] = 0;
      end
      m_v[wr_idx_i] = 1; m_vpn[wr_idx_i] = wr_vpn_i; m_ppn[wr_idx_i] = wr_ppn_i;
      m_sz[wr_idx_i] = wr_size_i; m_sub[wr_idx_i] = wr_sub_v_i; m_sup[wr_idx_i] = wr_sup_i;
      m_asid[wr_idx_i] = wr_asid_i; m_sh[wr_idx_i] = wr_shared_i; m_attr[wr_idx_i] = wr_attr_i;
    end
  endtask

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // compare with the model, then commit this cycle's write into it
  task automatic tick();
    bit h, f; bit [31:0] pa; bit [3:0] at;
    #1;
    model_lookup(h, f, pa, at);
    chk("R9/R2 model compare", {2'b0, hit_o, fault_o, attr_o, pa_o}, {2'b0, h, f, at, pa});
    model_update();
    @(negedge clk_i);
  endtask

  task automatic look(logic [31:0] va, logic [3:0] asid, logic sup);
    lk_va_i = va; lk_asid_i = asid; lk_sup_i = sup;
    #1;
  endtask

  task automatic expect_out(string req, logic h, logic f, logic [31:0] pa, logic [3:0] at);
    chk(req, {2'b0, hit_o, fault_o, attr_o, pa_o}, {2'b0, h, f, at, pa});
  endtask

  task automatic wr(int idx, logic [19:0] vpn, logic [19:0] ppn, logic [1:0] sz,
                    logic [3:0] sub, logic sup, logic [3:0] asid, logic sh, logic [3:0] at);
    wr_en_i = 1; wr_idx_i = 3'(idx); wr_vpn_i = vpn; wr_ppn_i = ppn; wr_size_i = sz;
    wr_sub_v_i = sub; wr_sup_i = sup; wr_asid_i = asid; wr_shared_i = sh; wr_attr_i = at;
  endtask

  task automatic idle();
    wr_en_i = 0; flush_i = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    // R1
    look(32'h0, 4'd0, 1); expect_out("R1 reset empty", 0, 0, 0, 0); tick();
    // R7: write, same-cycle lookup still misses
    wr(0, 20'h00010, 20'hABCD0, 2'd0, 4'hF, 0, 4'd1, 0, 4'h5);
    look(32'h0001_0123, 4'd1, 0); expect_out("R7 write cycle old view", 0, 0, 0, 0); tick();
    idle();
    look(32'h0001_0123, 4'd1, 0); expect_out("R2 4K hit", 1, 0, 32'hABCD_0123, 4'h5); tick();
    look(32'h0001_0123, 4'd2, 0); expect_out("R5 asid mismatch", 0, 0, 0, 0); tick();
    // R3/R5: 16K shared page
    wr(1, 20'h00020, 20'h00300, 2'd1, 4'h0, 0, 4'd3, 1, 4'h6); tick(); idle();
    look(32'h0002_3456, 4'd7, 0); expect_out("R3 R5 16K shared", 1, 0, 32'h0030_3456, 4'h6); tick();
    // R4 subpages
    wr(2, 20'h00040, 20'h00050, 2'd0, 4'b0010, 0, 4'd1, 0, 4'h2); tick(); idle();
    look(32'h0004_0400, 4'd1, 0); expect_out("R4 subpage set", 1, 0, 32'h0005_0400, 4'h2); tick();
    look(32'h0004_0800, 4'd1, 0); expect_out("R4 subpage clear", 0, 0, 0, 0); tick();
    // R6 supervisor-only 512K
    wr(3, 20'h00080, 20'h00800, 2'd2, 4'h0, 1, 4'd1, 0, 4'h9); tick(); idle();
    look(32'h0008_ABCD, 4'd1, 0); expect_out("R6 user fault", 0, 1, 0, 0); tick();
    look(32'h0008_ABCD, 4'd1, 1); expect_out("R6 R3 sup hit", 1, 0, 32'h0080_ABCD, 4'h9); tick();
    // R8: 4K inside supervisor 512K purges it
    wr(4, 20'h00090, 20'h00111, 2'd0, 4'hF, 0, 4'd1, 0, 4'h3); tick(); idle();
    look(32'h000A_0000, 4'd1, 1); expect_out("R8 big page purged", 0, 0, 0, 0); tick();
    look(32'h0009_0010, 4'd1, 1); expect_out("R8 new page", 1, 0, 32'h0011_1010, 4'h3); tick();
    // R8: private 512K purges shared page, spares other asid
    wr(5, 20'h00000, 20'h01000, 2'd3, 4'h0, 0, 4'd9, 0, 4'h7); tick(); idle();
    look(32'h0002_3456, 4'd7, 0); expect_out("R8 shared purged", 0, 0, 0, 0); tick();
    look(32'h0001_0123, 4'd1, 0); expect_out("R8 other asid kept", 1, 0, 32'hABCD_0123, 4'h5); tick();
    look(32'h0002_3456, 4'd9, 0); expect_out("R3 512K code 3", 1, 0, 32'h0102_3456, 4'h7); tick();
    // R8: disjoint subpages coexist
    wr(6, 20'h00040, 20'h00060, 2'd0, 4'b0100, 0, 4'd1, 0, 4'h4); tick(); idle();
    look(32'h0004_0400, 4'd1, 0); expect_out("R8 disjoint kept", 1, 0, 32'h0005_0400, 4'h2); tick();
    look(32'h0004_0800, 4'd1, 0); expect_out("R8 disjoint new", 1, 0, 32'h0006_0800, 4'h4); tick();
    // R7 slot replacement
    wr(0, 20'h000C0, 20'h00777, 2'd0, 4'hF, 0, 4'd1, 0, 4'h1); tick(); idle();
    look(32'h0001_0123, 4'd1, 0); expect_out("R7 old contents gone", 0, 0, 0, 0); tick();
    look(32'h000C_0123, 4'd1, 0); expect_out("R7 replaced", 1, 0, 32'h0077_7123, 4'h1); tick();
    // R10 flush beats write
    wr(7, 20'h00100, 20'h00200, 2'd0, 4'hF, 0, 4'd1, 0, 4'h8); flush_i = 1; tick(); idle();
    look(32'h000C_0123, 4'd1, 0); expect_out("R10 flushed", 0, 0, 0, 0); tick();
    look(32'h0010_0000, 4'd1, 0); expect_out("R10 write dropped", 0, 0, 0, 0); tick();
    // R9 random phase against reference
    for (int n = 0; n < 4000; n++) begin
      wr_en_i     = ($urandom_range(0, 2) == 0);
      flush_i     = ($urandom_range(0, 63) == 0);
      wr_idx_i    = 3'($urandom_range(0, 7));
      wr_vpn_i    = 20'($urandom_range(0, 511));
      wr_ppn_i    = 20'($urandom);
      wr_size_i   = 2'($urandom_range(0, 3));
      wr_sub_v_i  = 4'($urandom);
      wr_sup_i    = ($urandom_range(0, 3) == 0);
      wr_asid_i   = 4'($urandom_range(0, 3));
      wr_shared_i = ($urandom_range(0, 3) == 0);
      wr_attr_i   = 4'($urandom);
      lk_va_i     = 32'($urandom_range(0, 32'h1F_FFFF));
      lk_asid_i   = 4'($urandom_range(0, 3));
      lk_sup_i    = 1'($urandom);
      tick();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule